// File: doc/BRIEF.md
# Dual-Issue Warp Issue Selector

This block decides, every clock cycle, which warps of a SIMT core may issue their next instruction. Each warp presents only the flags of the instruction at the head of its instruction buffer: a valid flag (the slot holds an instruction) and a ready flag (no outstanding dependency). Because only the head is looked at, issue inside a warp always stays in program order. A warp whose head is both valid and ready is eligible. Each warp also carries an age stamp. The stamp is taken from a global counter when the warp is launched, and a smaller value means an older warp.

There are two policies, chosen by a mode input. In single mode one lane (lane A) scans all warps with a greedy-then-oldest rule. The warp that issued last on the lane keeps the grant while it stays eligible. Otherwise the eligible warp with the smallest age stamp wins. In paired mode two such selectors run side by side. Lane A covers even-numbered warps and lane B covers odd-numbered warps, so up to two instructions leave per cycle, always from two different warps. Grants and issue strobes are combinational in the current inputs. The greedy history of each lane is registered at the rising clock edge.

Top module: `warp_issue_sched`

## Requirements
- R1: A warp is granted only if both its `headValid` bit and its `headReady` bit are 1. A valid head that is not ready is never granted.
- R2: With `pairMode` = 0 (single mode), `grantB` is all zero and `issueB` is 0. `grantA` has at most one bit set.
- R3: A lane keeps granting the warp it granted most recently while that warp is eligible and belongs to the lane's set, even if an older warp becomes eligible.
- R4: In all other cases a lane grants the eligible warp in its set with the smallest age stamp. Equal stamps go to the lower warp index. Warp i's stamp is `ageStamps[i*AGE_W +: AGE_W]`.
- R5: With `pairMode` = 1, lane A grants only even warp indices and lane B grants only odd warp indices.
- R6: In paired mode the two lanes choose independently, and each may issue in the same cycle. This gives up to two issues from different warps.
- R7: When no warp in a lane's set is eligible, that lane's grant is zero and its issue strobe is 0.
- R8: Each grant vector is zero or one-hot (bit i means warp i), and each issue strobe is 1 exactly when its grant is non-zero.
- R9: Reset (`rstN` low, asynchronous) clears both lanes' greedy history. The first grant after reset therefore follows the oldest-first rule.
- R10: After a mode change, a lane's history is honoured only if the remembered warp belongs to the lane's set in the new mode. Lane B's history is kept, but unused, while in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; history updates on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pairMode | input | 1 | 0 = single greedy-then-oldest lane, 1 = odd/even dual lanes |
| headValid | input | NUM_WARPS | Per-warp head instruction present |
| headReady | input | NUM_WARPS | Per-warp head instruction dependency-free |
| ageStamps | input | NUM_WARPS*AGE_W | Packed launch stamps, warp i at bits i*AGE_W |
| grantA | output | NUM_WARPS | One-hot grant of lane A (all warps or even warps) |
| grantB | output | NUM_WARPS | One-hot grant of lane B (odd warps, paired mode) |
| issueA | output | 1 | Lane A issues this cycle |
| issueB | output | 1 | Lane B issues this cycle |

## Verification
Grants and issue strobes settle in the same cycle that the head flags, stamps and mode are applied. The effect of a grant on the greedy choice appears only after the next rising edge. The bench therefore drives inputs on the falling edge and samples both lanes 2 ns later. It then advances its reference history as if the edge had taken place. An asynchronous reset clears history at once, so during reset the reference history is cleared before the expected values are computed.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIRED = 1'b1
  } issueMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pairMode;
    logic holdA;
    logic holdB;
  } schedStrobe_t;

endpackage

// File: rtl/wsched_oldest_pick.sv
module wsched_oldest_pick #(
  parameter int NUM_WARPS = 8,
  parameter int AGE_W     = 8
) (
  input  logic [NUM_WARPS-1:0]       candMask,
  input  logic [NUM_WARPS*AGE_W-1:0] ageStamps,
  output logic [NUM_WARPS-1:0]       pickOneHot,
  output logic                       pickAny
);

  localparam int IDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;

  logic [AGE_W-1:0] bestAge;
  logic [IDX_W-1:0] bestIdx;
  logic             found;

  // strict less-than keeps the lowest index on equal stamps
  always_comb begin
    found   = 1'b0;
    bestAge = '1;
    bestIdx = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (candMask[i] && (!found || (ageStamps[i*AGE_W +: AGE_W] < bestAge))) begin
        found   = 1'b1;
        bestAge = ageStamps[i*AGE_W +: AGE_W];
        bestIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pickOneHot = '0;
    if (found) pickOneHot[bestIdx] = 1'b1;
  end

  assign pickAny = found;

endmodule

// File: rtl/wsched_datapath.sv
module wsched_datapath
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  schedStrobe_t               strobe,
  input  logic [IDX_W-1:0]           lastIdxA,
  input  logic [IDX_W-1:0]           lastIdxB,
  input  logic [NUM_WARPS-1:0]       headValid,
  input  logic [NUM_WARPS-1:0]       headReady,
  input  logic [NUM_WARPS*AGE_W-1:0] ageStamps,
  output logic [NUM_WARPS-1:0]       eligible,
  output logic [NUM_WARPS-1:0]       grantA,
  output logic [NUM_WARPS-1:0]       grantB,
  output logic                       issueA,
  output logic                       issueB
);

  localparam logic [NUM_WARPS-1:0] WARP_ONE = NUM_WARPS'(1);

  logic [NUM_WARPS-1:0] oddMask;
  logic [NUM_WARPS-1:0] candA, candB;
  logic [NUM_WARPS-1:0] pickA, pickB;
  logic                 anyA, anyB;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : gParity
    assign oddMask[g] = (g % 2) == 1;
  end

  assign eligible = headValid & headReady;

  always_comb begin
    if (strobe.pairMode) begin
      candA = eligible & ~oddMask;
      candB = eligible & oddMask;
    end else begin
      candA = eligible;
      candB = '0;
    end
  end

  wsched_oldest_pick #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) uPickA (
    .candMask(candA), .ageStamps(ageStamps), .pickOneHot(pickA), .pickAny(anyA)
  );

  wsched_oldest_pick #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) uPickB (
    .candMask(candB), .ageStamps(ageStamps), .pickOneHot(pickB), .pickAny(anyB)
  );

  assign grantA = strobe.holdA ? (WARP_ONE << lastIdxA) : pickA;
  assign grantB = strobe.holdB ? (WARP_ONE << lastIdxB) : pickB;
  assign issueA = strobe.holdA | anyA;
  assign issueB = strobe.holdB | anyB;

  // R1
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((grantA | grantB) & ~eligible) == '0);

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantA) && $onehot0(grantB) && (issueA == (grantA != '0)) && (issueB == (grantB != '0)));

  // R2
  single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pairMode |-> (!issueB && grantB == '0));

  // R5
  parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pairMode |-> (((grantA & oddMask) == '0) && ((grantB & ~oddMask) == '0)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdA |-> grantA[lastIdxA]);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eligible == '0) |-> (!issueA && !issueB));

endmodule

// File: rtl/wsched_control.sv
module wsched_control
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int IDX_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pairModeIn,
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic [NUM_WARPS-1:0] grantA,
  input  logic [NUM_WARPS-1:0] grantB,
  input  logic                 issueA,
  input  logic                 issueB,
  output schedStrobe_t         strobe,
  output logic [IDX_W-1:0]     lastIdxA,
  output logic [IDX_W-1:0]     lastIdxB
);

  issueMode_e mode;
  logic       lastValidA, lastValidB;

  function automatic logic [IDX_W-1:0] idxOf(input logic [NUM_WARPS-1:0] vec);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (vec[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign mode = issueMode_e'(pairModeIn);

  always_comb begin
    strobe.pairMode = (mode == MODE_PAIRED);
    strobe.holdA    = lastValidA && eligible[lastIdxA] &&
                      ((mode == MODE_SINGLE) || !lastIdxA[0]);
    strobe.holdB    = (mode == MODE_PAIRED) && lastValidB &&
                      eligible[lastIdxB] && lastIdxB[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastValidA <= 1'b0;
      lastIdxA   <= '0;
    end else if (issueA) begin
      lastValidA <= 1'b1;
      lastIdxA   <= idxOf(grantA);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastValidB <= 1'b0;
      lastIdxB   <= '0;
    end else if (issueB) begin
      lastValidB <= 1'b1;
      lastIdxB   <= idxOf(grantB);
    end
  end

  // R3
  history_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueA |=> (lastValidA && (lastIdxA == idxOf($past(grantA)))));

  // R10
  history_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueB |=> $stable(lastIdxB));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int AGE_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pairMode,
  input  logic [NUM_WARPS-1:0]       headValid,
  input  logic [NUM_WARPS-1:0]       headReady,
  input  logic [NUM_WARPS*AGE_W-1:0] ageStamps,
  output logic [NUM_WARPS-1:0]       grantA,
  output logic [NUM_WARPS-1:0]       grantB,
  output logic                       issueA,
  output logic                       issueB
);

  localparam int IDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;

  schedStrobe_t         strobe;
  logic [IDX_W-1:0]     lastIdxA, lastIdxB;
  logic [NUM_WARPS-1:0] eligible;

  wsched_control #(.NUM_WARPS(NUM_WARPS)) uCtrl (
    .clk(clk), .rstN(rstN), .pairModeIn(pairMode), .eligible(eligible),
    .grantA(grantA), .grantB(grantB), .issueA(issueA), .issueB(issueB),
    .strobe(strobe), .lastIdxA(lastIdxA), .lastIdxB(lastIdxB)
  );

  wsched_datapath #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lastIdxA(lastIdxA), .lastIdxB(lastIdxB),
    .headValid(headValid), .headReady(headReady), .ageStamps(ageStamps),
    .eligible(eligible), .grantA(grantA), .grantB(grantB),
    .issueA(issueA), .issueB(issueB)
  );

endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pairMode = 1'b0;
  logic [N-1:0] headValid = '0, headReady = '0;
  logic [N*AW-1:0] ageStamps = '0;
  logic [N-1:0] grantA, grantB;
  logic issueA, issueB;

  int checks = 0, errors = 0;
  logic [AW-1:0] ageArr [N];
  bit mValidA = 0, mValidB = 0;
  int mLastA = 0, mLastB = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .AGE_W(AW)) uut (
    .clk(clk), .rstN(rstN), .pairMode(pairMode), .headValid(headValid),
    .headReady(headReady), .ageStamps(ageStamps), .grantA(grantA), .grantB(grantB),
    .issueA(issueA), .issueB(issueB)
  );

  // R4: oldest stamp, lower index on ties
  function automatic int oldest(input logic [N-1:0] m);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (best < 0 || ageArr[i] < ageArr[best])) best = i;
    return best;
  endfunction

  task automatic stepCheck(input string tag);
    logic [N-1:0] elig, candA, candB, expA, expB;
    int pa, pb;
    for (int i = 0; i < N; i++) ageStamps[i*AW +: AW] = ageArr[i];
    if (!rstN) begin mValidA = 0; mValidB = 0; end  // R9
    #2;
    elig = headValid & headReady;  // R1
    candA = '0; candB = '0;
    for (int i = 0; i < N; i++) begin
      if (!pairMode || (i % 2 == 0)) candA[i] = elig[i];  // R5
      if (pairMode && (i % 2 == 1))  candB[i] = elig[i];
    end
    expA = '0; expB = '0;
    if (mValidA && elig[mLastA] && (!pairMode || mLastA % 2 == 0)) expA[mLastA] = 1'b1;  // R3 R10
    else begin pa = oldest(candA); if (pa >= 0) expA[pa] = 1'b1; end
    if (pairMode && mValidB && elig[mLastB] && (mLastB % 2 == 1)) expB[mLastB] = 1'b1;
    else begin pb = oldest(candB); if (pb >= 0) expB[pb] = 1'b1; end
    checks++;
    if (grantA !== expA || issueA !== (expA != '0)) begin
      errors++;
      $display("FAIL %s lane A: grant=%b issue=%b expected grant=%b issue=%b",
               tag, grantA, issueA, expA, expA != '0);
    end
    checks++;
    if (grantB !== expB || issueB !== (expB != '0)) begin
      errors++;
      $display("FAIL %s lane B: grant=%b issue=%b expected grant=%b issue=%b",
               tag, grantB, issueB, expB, expB != '0);
    end
    if (rstN) begin
      for (int i = 0; i < N; i++) begin
        if (expA[i]) begin mValidA = 1; mLastA = i; end
        if (expB[i]) begin mValidB = 1; mLastB = i; end
      end
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) ageArr[i] = AW'(i * 3);
    @(negedge clk);
    stepCheck("R9 reset idle");
    headValid = 8'hFF; headReady = 8'hFF;
    stepCheck("R9 reset oldest");
    rstN = 1'b1;
    // single mode: 2 and 5 eligible, 5 older
    headValid = 8'b0010_0101; headReady = 8'b0010_0100;
    ageArr[2] = 30; ageArr[5] = 10; ageArr[0] = 0;
    stepCheck("R4 R1 oldest, valid-not-ready ignored");
    headValid[1] = 1'b1; headReady[1] = 1'b1; ageArr[1] = 3;
    stepCheck("R3 greedy hold");
    headReady[5] = 1'b0;
    stepCheck("R4 switch to oldest");
    headValid = 8'b0100_1010; headReady = 8'b0100_1000; ageArr[3] = 7; ageArr[6] = 7;
    stepCheck("R4 tie lower index");
    stepCheck("R2 single lane only");
    // paired mode: lane A history is odd warp 3
    pairMode = 1'b1; headValid = 8'hFF; headReady = 8'hFF;
    for (int i = 0; i < N; i++) ageArr[i] = AW'(100 - i);
    stepCheck("R10 R5 R6 dual issue");
    stepCheck("R6 R3 dual hold");
    headReady = 8'h00;
    stepCheck("R7 nothing eligible");
    headReady = 8'h0F;
    stepCheck("R7 R6 partial");
    pairMode = 1'b0; headReady = 8'hF0;
    stepCheck("R10 back to single");
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 16 == 0) pairMode = ~pairMode;
      for (int i = 0; i < N; i++) begin
        headValid[i] = ($urandom % 10) < 7;
        headReady[i] = ($urandom % 10) < 6;
        if ($urandom % 32 == 0) ageArr[i] = AW'($urandom % 8);
      end
      if (c == 1500) begin rstN = 1'b0; stepCheck("R9 mid reset"); rstN = 1'b1; end
      stepCheck("R4 R6 R8 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule